// File: doc/BRIEF.md
# Windowed Toggle Watchdog Monitor

This block supervises a heartbeat line that a companion circuit must keep toggling. Each level of the heartbeat has a valid duration. It must be at least a programmed minimum number of clock cycles and at most a programmed maximum. A level change that arrives too soon is a violation. A level that is held past the maximum is also a violation. In both cases the monitor drops its OK output and raises its fault output. It then stays in that fault state, whatever the heartbeat does, until the next reset.

The heartbeat is asynchronous, so it first passes through a two-stage synchroniser and an edge detector. The controller has three states: expecting a rise, expecting a fall, and latched fault. Two saturating timers run alongside it. One shows when the minimum has been met and the other shows when the maximum has been reached. Both restart on every accepted edge. The two limits are captured while reset is held, so software or straps can set them before the guarded function is enabled.

Top module: `hbeat_window_guard`

## Requirements
- R1: While reset is asserted and on the first clock after it, `ok` is 1, `fault` is 0, and the monitor expects a rising heartbeat.
- R2: `fault` is always the inverse of `ok`, and both change only on a rising clock edge.
- R3: A heartbeat level change is accepted, and `ok` stays 1, when the spacing in clock cycles between it and the previous accepted change lies within [min, max] inclusive.
- R4: A rising heartbeat change whose spacing is below min sets `fault`. The fault is visible after the third rising clock edge that follows the input change: two edges for synchronisation and one edge for the judgement.
- R5: If no change has arrived max cycles after the previous accepted change was judged, `fault` is set on that clock edge.
- R6: A falling heartbeat change whose spacing is below min sets `fault` with the same latency as in R4, so both the high and the low phase are windowed.
- R7: Once `fault` is 1 it stays 1, whatever the heartbeat does, until reset. A new reset restores `ok`.
- R8: The `min_cycles` and `max_cycles` inputs are sampled only while reset is asserted. Changes made after reset is released have no effect.
- R9: If the captured min is greater than the captured max, `fault` is set on the first clock edge after reset is released.
- R10: When min equals max, only the exact spacing is accepted. One cycle less is an early fault, and one cycle more is a timeout.
- R11: The first heartbeat phase is timed from the first clock edge at which reset is low, counted with the same synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also the limit capture window |
| hb_in | input | 1 | Asynchronous heartbeat line |
| min_cycles | input | LIM_W | Shortest allowed level duration, in clock cycles |
| max_cycles | input | LIM_W | Longest allowed level duration, in clock cycles |
| ok | output | 1 | Registered enable; 1 while no violation has occurred |
| fault | output | 1 | Registered latched violation flag, inverse of ok |

## Verification
A wrong internal state shows at the ports as a fault that comes one or more cycles too early or too late, or as a fault that never comes. The bench therefore predicts the exact clock edge of every expected change on `ok`/`fault` and also requires `ok` one cycle earlier. A timer that is off by one shows at the first edge placed on a window boundary. A controller that swaps its expected polarity faults on the very first accepted edge. A non-sticky fault shows at the next heartbeat toggle after a violation.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  // Controller states: expecting a rise, expecting a fall, terminal fault.
  typedef enum logic [1:0] {
    HBW_AWAIT_RISE = 2'b00,
    HBW_AWAIT_FALL = 2'b01,
    HBW_LATCHED    = 2'b10
  } hbw_state_e;

  // Per-cycle judgement of the heartbeat against the window.
  typedef struct packed {
    logic accept;   // edge inside [min, max]
    logic early;    // edge before min
    logic late;     // max reached with no edge
    logic bad_cfg;  // limits inconsistent
  } hbw_verdict_t;

  // Limits are inconsistent when the lower bound exceeds the upper one.
  function automatic logic hbw_limits_bad(input logic [31:0] lo, input logic [31:0] hi);
    return lo > hi;
  endfunction

  // A timer has reached its bound once its count is at or above it.
  function automatic logic hbw_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // Classify the current cycle. An edge takes priority over expiry, so an
  // edge exactly at the maximum is still accepted.
  function automatic hbw_verdict_t hbw_judge(input logic waiting,
                                             input logic cfg_bad,
                                             input logic edge_seen,
                                             input logic min_met,
                                             input logic max_hit);
    hbw_verdict_t v;
    v = '0;
    if (waiting) begin
      if (cfg_bad) begin
        v.bad_cfg = 1'b1;
      end else if (edge_seen) begin
        if (min_met) v.accept = 1'b1;
        else         v.early  = 1'b1;
      end else if (max_hit) begin
        v.late = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic hbw_state_e hbw_next_state(input hbw_state_e cur, input hbw_verdict_t v);
    hbw_state_e nxt;
    nxt = cur;
    if (v.bad_cfg || v.early || v.late) begin
      nxt = HBW_LATCHED;
    end else if (v.accept) begin
      nxt = (cur == HBW_AWAIT_RISE) ? HBW_AWAIT_FALL : HBW_AWAIT_RISE;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign rise = chain_q[LAST] & ~prev_q;
  assign fall = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/hbw_limit_timer.sv
module hbw_limit_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] cnt_q;

  assign reached = hbw_pkg::hbw_reached(32'(cnt_q), 32'(limit));

  // Saturates at its bound; restart loads 1 so the count equals the
  // number of cycles elapsed since the restarting edge was judged.
  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (restart)         cnt_q <= W'(1);
    else if (run && !reached) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/hbw_limit_capture.sv
module hbw_limit_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

  assign bad = hbw_pkg::hbw_limits_bad(32'(lo_q), 32'(hi_q));
endmodule

// File: rtl/hbeat_window_guard.sv
module hbeat_window_guard #(
  parameter int LIM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_in,
  input  logic [LIM_W-1:0] min_cycles,
  input  logic [LIM_W-1:0] max_cycles,
  output logic             ok,
  output logic             fault
);
  import hbw_pkg::*;

  localparam int N_TIMERS  = 2;
  localparam int TIMER_MIN = 0;
  localparam int TIMER_MAX = 1;

  // Named internal events, brought out for the checker.
  logic         hb_rise;
  logic         hb_fall;
  logic         cfg_bad;
  logic         min_met;
  logic         max_hit;
  logic         edge_here;
  logic         waiting;
  logic         accept;
  hbw_verdict_t verdict;
  hbw_state_e   state_q;
  hbw_state_e   state_d;
  logic         ok_q;
  logic         fault_q;

  logic [LIM_W-1:0] lo_q;
  logic [LIM_W-1:0] hi_q;
  logic [LIM_W-1:0] bound [N_TIMERS];
  logic             hit   [N_TIMERS];

  hbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (hb_in),
    .rise     (hb_rise),
    .fall     (hb_fall)
  );

  hbw_limit_capture #(.W(LIM_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .lo_in (min_cycles),
    .hi_in (max_cycles),
    .lo_q  (lo_q),
    .hi_q  (hi_q),
    .bad   (cfg_bad)
  );

  assign bound[TIMER_MIN] = lo_q;
  assign bound[TIMER_MAX] = hi_q;

  genvar t;
  generate
    for (t = 0; t < N_TIMERS; t++) begin : g_timer
      hbw_limit_timer #(.W(LIM_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .restart (accept),
        .limit   (bound[t]),
        .reached (hit[t])
      );
    end
  endgenerate

  assign min_met = hit[TIMER_MIN];
  assign max_hit = hit[TIMER_MAX];

  assign waiting   = (state_q != HBW_LATCHED);
  assign edge_here = (state_q == HBW_AWAIT_RISE) ? hb_rise :
                     (state_q == HBW_AWAIT_FALL) ? hb_fall : 1'b0;

  always_comb begin
    verdict = hbw_judge(waiting, cfg_bad, edge_here, min_met, max_hit);
    state_d = hbw_next_state(state_q, verdict);
  end

  assign accept = verdict.accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HBW_AWAIT_RISE;
      ok_q    <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= (state_d != HBW_LATCHED);
      fault_q <= (state_d == HBW_LATCHED);
    end
  end

  assign ok    = ok_q;
  assign fault = fault_q;
endmodule

// File: rtl/hbw_guard_checker.sv
module hbw_guard_checker (
  input logic       clk,
  input logic       rst,
  input logic       ok,
  input logic       fault,
  input logic [1:0] state,
  input logic       rise,
  input logic       fall,
  input logic       min_met,
  input logic       max_hit,
  input logic       cfg_bad,
  input logic       accept
);
  import hbw_pkg::*;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ok && !fault && state == HBW_AWAIT_RISE));

  assert_ok_fault_complement_R2: assert property (@(posedge clk) disable iff (rst)
    ok != fault);

  assert_accept_keeps_ok_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> ok);

  assert_early_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (state == HBW_AWAIT_RISE && rise && !min_met) |=> fault);

  assert_timeout_R5: assert property (@(posedge clk) disable iff (rst)
    (state != HBW_LATCHED && max_hit && !rise && !fall) |=> fault);

  assert_early_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (state == HBW_AWAIT_FALL && fall && !min_met) |=> fault);

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  assert_bad_limits_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> fault);
endmodule

bind hbeat_window_guard hbw_guard_checker u_hbw_chk (
  .clk     (clk),
  .rst     (rst),
  .ok      (ok),
  .fault   (fault),
  .state   (state_q),
  .rise    (hb_rise),
  .fall    (hb_fall),
  .min_met (min_met),
  .max_hit (max_hit),
  .cfg_bad (cfg_bad),
  .accept  (accept)
);

// File: tb/hbeat_window_guard_bench.sv
module hbeat_window_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb  = 1'b0;
  logic [15:0] min_c = 16'd4;
  logic [15:0] max_c = 16'd10;
  logic        ok;
  logic        fault;

  always #10 clk = ~clk;  // 50 MHz

  hbeat_window_guard u_hbeat_window_guard (
    .clk        (clk),
    .rst        (rst),
    .hb_in      (hb),
    .min_cycles (min_c),
    .max_cycles (max_c),
    .ok         (ok),
    .fault      (fault)
  );

  typedef struct {
    int    cyc;
    bit    exp_fault;
    string req;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;

  // Reference model state (from the requirements only).
  int    prev_tog;
  bit    m_fault;
  int    m_lo;
  int    m_hi;
  string tag_ovr = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tally(input bit good, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic void push(input int c, input bit f, input string r);
    item_t it;
    it.cyc = c; it.exp_fault = f; it.req = r;
    sb.push_back(it);
  endfunction

  // Monitor: compares scoreboard items in the cycle they are due.
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      if (cyc >= 1) tally(ok != fault, "R2", "ok/fault complement", int'(ok), int'(!fault));
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        item_t it;
        it = sb.pop_front();
        if (it.cyc < cyc) begin
          tally(1'b0, it.req, "item missed at cycle", cyc, it.cyc);
        end else begin
          tally(fault == it.exp_fault && ok == !it.exp_fault, it.req, "fault",
                int'(fault), int'(it.exp_fault));
        end
      end
    end
  end

  task automatic reset_dut(input int lo, input int hi, input string ovr);
    @(negedge clk);
    rst = 1'b1; hb = 1'b0;
    min_c = 16'(lo); max_c = 16'(hi);
    sb.delete();
    repeat (3) @(negedge clk);
    tally(ok == 1'b1 && fault == 1'b0, "R1", "ok during reset", int'(ok), 1);
    rst = 1'b0;
    tag_ovr  = ovr;
    prev_tog = cyc - 2;
    m_fault  = 1'b0;
    m_lo = lo; m_hi = hi;
    if (lo > hi) begin
      push(cyc + 1, 1'b1, (ovr != "") ? ovr : "R9");
      m_fault = 1'b1;
    end else begin
      push(cyc + 1, 1'b0, (ovr != "") ? ovr : "R1");
    end
  endtask

  // Predict the outcome of a toggle that will happen gap cycles from now.
  task automatic step(input int gap);
    int    c;
    int    el;
    bit    rising;
    string t_ok;
    string t_er;
    string t_lt;
    c      = cyc + gap;
    rising = (hb == 1'b0);
    t_ok = (tag_ovr != "") ? tag_ovr : "R3";
    t_er = (tag_ovr != "") ? tag_ovr : (rising ? "R4" : "R6");
    t_lt = (tag_ovr != "") ? tag_ovr : "R5";
    if (m_fault) begin
      push(c + 3, 1'b1, "R7");
    end else begin
      el = c - prev_tog;
      if (el > m_hi) begin
        push(prev_tog + 2 + m_hi, 1'b0, t_lt);
        push(prev_tog + 3 + m_hi, 1'b1, t_lt);
        m_fault = 1'b1;
        push(c + 3, 1'b1, "R7");
      end else if (el < m_lo) begin
        push(c + 2, 1'b0, t_er);
        push(c + 3, 1'b1, t_er);
        m_fault = 1'b1;
      end else begin
        push(c + 3, 1'b0, t_ok);
        prev_tog = c;
      end
    end
    repeat (gap) @(negedge clk);
    hb = ~hb;
  endtask

  task automatic quiet(input int n);
    int c;
    c = cyc + n;
    if (!m_fault && (c - prev_tog) > m_hi) begin
      push(prev_tog + 2 + m_hi, 1'b0, (tag_ovr != "") ? tag_ovr : "R5");
      push(prev_tog + 3 + m_hi, 1'b1, (tag_ovr != "") ? tag_ovr : "R5");
      m_fault = 1'b1;
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    tally(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    // R3 accepted windows on both levels, then R4 early rise, then R7 sticky.
    reset_dut(4, 10, "");
    step(4); step(4); step(10); step(7); step(5); step(10);
    step(3);
    step(4); step(4); step(6);
    quiet(4);
    drain();

    // R7 recovery by reset, then R5 timeout and sticky fault.
    reset_dut(4, 10, "");
    step(5); step(6);
    quiet(15);
    step(3); step(3);
    drain();

    // R6 early falling edge.
    reset_dut(4, 10, "");
    step(5); step(2);
    drain();

    // R10 narrow window: exact accepted, one short faults.
    reset_dut(6, 6, "R10");
    step(4); step(6); step(6); step(5);
    drain();

    // R10 narrow window: one long times out.
    reset_dut(6, 6, "R10");
    step(4); step(7);
    drain();

    // R9 inconsistent limits.
    reset_dut(9, 3, "");
    step(5);
    drain();

    // R8 limits changed after reset are ignored.
    reset_dut(4, 10, "R8");
    @(negedge clk);
    min_c = 16'd20; max_c = 16'd2;
    step(4); step(10); step(5); step(9);
    drain();

    // R11 first phase timed from reset release: early, then timeout.
    reset_dut(4, 10, "R11");
    step(1);
    drain();
    reset_dut(4, 10, "R11");
    quiet(14);
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule